// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects up to 32 external request lines and decides which one a processor core should service next. A rising edge on a line marks it pending. Each line has a software-written 2-bit urgency level and an enable bit. Among enabled pending lines the controller picks the most urgent level. Within one level the line waiting longest wins, and lines that arrived together are ordered by line number. The winner is registered, so a change in pending, enable or level state is reflected in the next cycle.

The controller keeps a bounded stack of handlers that are running, one inside another. While the core is idle it requests an entry. While a handler runs it signals preemption only when the winner is strictly more urgent than that handler. When the core reports that a handler has finished, the controller either pops back to the interrupted level or chains straight into a pending line that outranks it. A global disable keeps latching requests but stops every entry, preemption and chain. A byte-wide register port holds the levels, the enables and the disable bit. Saving context, fetching vectors and stack memory stay with the core.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A line becomes pending on a rising edge of its request input, with a rising edge sampled at a clock edge where the previous sample was low. It stays pending while other handlers run and clears only when the core takes that line, either through an entry or through a chain.
- R2: The level of line i lives at register address i (0..31) as an 8-bit value whose bits [7:6] hold the level and whose bits [5:0] read as zero. Level 0 is the most urgent and 3 the least. All levels are 0 after reset.
- R3: The enable bit of line i is bit i%8 of the register at address 32 + i/8, and all enables are 0 after reset. A disabled line still latches pending but takes no part in arbitration until it is enabled.
- R4: Among enabled pending lines, the smallest level wins. On equal levels the earlier arrival wins, and on equal arrival cycles the lower line number wins. The registered winner is valid one cycle after the state change.
- R5: With no active handler, `entry_req` is high whenever an eligible winner exists, and `entry_vec` gives its line number.
- R6: With a handler active, `entry_req` and `preempt` rise only when the winner's level is strictly smaller than the running handler's level. An equal or less urgent request waits.
- R7: A `core_take` pulse while `entry_req` is high pushes the winner onto the active stack. This raises `act_depth` by one and sets `act_vec` to the winner.
- R8: On `core_done`, the controller chains if an eligible winner is more urgent than the interrupted context, or if there is no interrupted context. A chain replaces the finished handler with the winner, keeps the depth and pulses `done_chain` in the next cycle. Otherwise the controller pops one level and pulses `done_ret` in the next cycle.
- R9: Bit 0 of register address 36 is a global disable, reset 0. While it is set, lines still latch pending, but `entry_req`, `preempt` and chaining stay off.
- R10: The active stack holds at most MAX_DEPTH (default 16) handlers. At full depth no entry or preemption is signalled.
- R11: A `core_take` without `entry_req` and a `core_done` with no active handler leave the stack unchanged and produce no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 32 | Request lines, edge-sensitive |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational from address |
| core_take | input | 1 | Core accepts the offered entry |
| core_done | input | 1 | Core finished the running handler |
| entry_req | output | 1 | An entry or preemption is offered |
| preempt | output | 1 | The offered entry interrupts a running handler |
| entry_vec | output | 5 | Line number of the offered entry |
| act_vec | output | 5 | Line number of the running handler |
| act_depth | output | 5 | Number of active handlers |
| done_ret | output | 1 | Pulse: completion returned to the interrupted level |
| done_chain | output | 1 | Pulse: completion chained into a pending line |

## Verification
Arbitration is driven with pairs of requests that separate three orderings. Equal levels with staggered arrival, including the case where the older line has the higher number, show that arrival order is used rather than line number. Equal levels arriving in the same cycle show the line-number fallback. Unequal levels show that urgency overrides age. Nesting sequences mix more urgent, equal and less urgent arrivals during a running handler, so that preemption, waiting, chaining and popping back can each be told apart. A second instance with a shallow stack exposes the depth limit.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int PRIO_W = 2;
  localparam int KEY_AGE_W = 16;

  typedef logic [PRIO_W-1:0] prio_t;

  // level held in the top two bits of a byte register
  function automatic prio_t prio_field(input logic [7:0] b);
    return b[7:6];
  endfunction

  function automatic logic [7:0] prio_byte(input prio_t p);
    return {p, 6'b000000};
  endfunction

  // candidate a beats incumbent b: more urgent level, or same level and older
  function automatic logic beats(input prio_t pa, input logic [KEY_AGE_W-1:0] aa,
                                 input prio_t pb, input logic [KEY_AGE_W-1:0] ab);
    return (pa < pb) || ((pa == pb) && (aa > ab));
  endfunction
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_nest_pkg::*;
#(
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             prio_we,
  input  prio_t            prio_wd,
  input  logic             en_we,
  input  logic             en_wd,
  input  logic             clr,
  output logic             pend,
  output logic             en,
  output prio_t            prio,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_SAT = '1;

  logic req_q;
  logic rise;

  assign rise = req && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
      age   <= '0;
    end else begin
      req_q <= req;
      if (rise) begin
        pend <= 1'b1;
        age  <= '0;
      end else begin
        if (clr) pend <= 1'b0;
        if (pend && age != AGE_SAT) age <= age + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio <= '0;
      en   <= 1'b0;
    end else begin
      if (prio_we) prio <= prio_wd;
      if (en_we)   en   <= en_wd;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int AGE_W   = 6,
  parameter int LINE_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IRQ-1:0]            elig,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  input  logic [NUM_IRQ-1:0][AGE_W-1:0] age,
  output logic                          win_valid,
  output logic [LINE_W-1:0]             win_line,
  output prio_t                         win_prio
);
  logic              found;
  logic [LINE_W-1:0] best_line;
  prio_t             best_prio;
  logic [AGE_W-1:0]  best_age;

  // linear scan: a strict win is needed to displace, so lower lines keep ties
  always_comb begin
    found     = 1'b0;
    best_line = '0;
    best_prio = '0;
    best_age  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!found ||
          beats(prio[i], KEY_AGE_W'(age[i]), best_prio, KEY_AGE_W'(best_age)))) begin
        found     = 1'b1;
        best_line = LINE_W'(i);
        best_prio = prio[i];
        best_age  = age[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_line  <= '0;
      win_prio  <= '0;
    end else begin
      win_valid <= found;
      win_line  <= best_line;
      win_prio  <= best_prio;
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_nest_pkg::*;
#(
  parameter int MAX_DEPTH = 16,
  parameter int LINE_W    = 5,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic               swap,
  input  logic [LINE_W-1:0]  in_vec,
  input  prio_t              in_prio,
  output logic [DEPTH_W-1:0] depth,
  output logic [LINE_W-1:0]  top_vec,
  output prio_t              top_prio,
  output logic               below_valid,
  output prio_t              below_prio
);
  localparam int IDX_W = $clog2(MAX_DEPTH);

  logic [LINE_W-1:0] vec_mem  [MAX_DEPTH];
  prio_t             prio_mem [MAX_DEPTH];
  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  below_idx;
  logic [IDX_W-1:0]  push_idx;

  assign top_idx   = IDX_W'(depth - DEPTH_W'(1));
  assign below_idx = IDX_W'(depth - DEPTH_W'(2));
  assign push_idx  = IDX_W'(depth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < MAX_DEPTH; i++) begin
        vec_mem[i]  <= '0;
        prio_mem[i] <= '0;
      end
    end else if (push) begin
      vec_mem[push_idx]  <= in_vec;
      prio_mem[push_idx] <= in_prio;
      depth <= depth + DEPTH_W'(1);
    end else if (swap) begin
      vec_mem[top_idx]  <= in_vec;
      prio_mem[top_idx] <= in_prio;
    end else if (pop) begin
      depth <= depth - DEPTH_W'(1);
    end
  end

  assign top_vec     = (depth != '0) ? vec_mem[top_idx] : '0;
  assign top_prio    = (depth != '0) ? prio_mem[top_idx] : '1;
  assign below_valid = (depth >= DEPTH_W'(2));
  assign below_prio  = below_valid ? prio_mem[below_idx] : '1;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int MAX_DEPTH = 16,
  parameter int AGE_W     = 6,
  parameter int ADDR_W    = 6,
  parameter int LINE_W    = $clog2(NUM_IRQ),
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               core_take,
  input  logic               core_done,
  output logic               entry_req,
  output logic               preempt,
  output logic [LINE_W-1:0]  entry_vec,
  output logic [LINE_W-1:0]  act_vec,
  output logic [DEPTH_W-1:0] act_depth,
  output logic               done_ret,
  output logic               done_chain
);
  localparam int EN_BYTES  = (NUM_IRQ + 7) / 8;
  localparam int EN_PAD_W  = EN_BYTES * 8;
  localparam int EN_BASE   = NUM_IRQ;
  localparam int CTRL_ADDR = EN_BASE + EN_BYTES;

  logic [NUM_IRQ-1:0]             line_pend;
  logic [NUM_IRQ-1:0]             line_en;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] line_prio;
  logic [NUM_IRQ-1:0][AGE_W-1:0]  line_age;
  logic [NUM_IRQ-1:0]             line_prio_we;
  logic [NUM_IRQ-1:0]             line_en_we;
  logic [NUM_IRQ-1:0]             line_clr;
  logic [EN_PAD_W-1:0]            en_pad;

  logic              glob_dis;
  logic              win_valid;
  logic [LINE_W-1:0] win_line;
  prio_t             win_prio;
  logic              win_live;
  logic              room;
  logic              offer;
  logic              take_ok;
  logic              done_ok;
  logic              chain_ok;
  logic              pop_ok;
  prio_t             top_prio;
  logic              below_valid;
  prio_t             below_prio;

  // per-line pending, age and configuration
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign line_prio_we[g] = cfg_we && (cfg_addr == ADDR_W'(g));
    assign line_en_we[g]   = cfg_we && (cfg_addr == ADDR_W'(EN_BASE + g / 8));
    assign line_clr[g]     = (take_ok || chain_ok) && (win_line == LINE_W'(g));

    irq_line_cell #(.AGE_W(AGE_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (irq_req[g]),
      .prio_we (line_prio_we[g]),
      .prio_wd (prio_field(cfg_wdata)),
      .en_we   (line_en_we[g]),
      .en_wd   (cfg_wdata[g % 8]),
      .clr     (line_clr[g]),
      .pend    (line_pend[g]),
      .en      (line_en[g]),
      .prio    (line_prio[g]),
      .age     (line_age[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_dis <= 1'b0;
    else if (cfg_we && cfg_addr == ADDR_W'(CTRL_ADDR)) glob_dis <= cfg_wdata[0];
  end

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .AGE_W(AGE_W), .LINE_W(LINE_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (line_pend & line_en),
    .prio      (line_prio),
    .age       (line_age),
    .win_valid (win_valid),
    .win_line  (win_line),
    .win_prio  (win_prio)
  );

  // registered winner is re-qualified against live state so a taken line is not offered twice
  assign win_live = win_valid && line_pend[win_line] && line_en[win_line] && !glob_dis;
  assign room     = act_depth < DEPTH_W'(MAX_DEPTH);
  assign offer    = win_live && room && ((act_depth == '0) || (win_prio < top_prio));
  assign take_ok  = core_take && offer && !core_done;
  assign done_ok  = core_done && (act_depth != '0);
  assign chain_ok = done_ok && win_live && (!below_valid || (win_prio < below_prio));
  assign pop_ok   = done_ok && !chain_ok;

  irq_nest_stack #(.MAX_DEPTH(MAX_DEPTH), .LINE_W(LINE_W), .DEPTH_W(DEPTH_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (take_ok),
    .pop         (pop_ok),
    .swap        (chain_ok),
    .in_vec      (win_line),
    .in_prio     (win_prio),
    .depth       (act_depth),
    .top_vec     (act_vec),
    .top_prio    (top_prio),
    .below_valid (below_valid),
    .below_prio  (below_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_ret   <= 1'b0;
      done_chain <= 1'b0;
    end else begin
      done_ret   <= pop_ok;
      done_chain <= chain_ok;
    end
  end

  assign entry_req = offer;
  assign preempt   = offer && (act_depth != '0);
  assign entry_vec = win_line;
  assign en_pad    = EN_PAD_W'(line_en);

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (cfg_addr == ADDR_W'(i)) cfg_rdata = prio_byte(line_prio[i]);
    for (int b = 0; b < EN_BYTES; b++)
      if (cfg_addr == ADDR_W'(EN_BASE + b)) cfg_rdata = en_pad[b*8 +: 8];
    if (cfg_addr == ADDR_W'(CTRL_ADDR)) cfg_rdata = {7'b0000000, glob_dis};
  end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int MAX_DEPTH = 16,
  parameter int DEPTH_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_take,
  input logic               core_done,
  input logic               entry_req,
  input logic               preempt,
  input logic [DEPTH_W-1:0] act_depth,
  input logic               done_ret,
  input logic               done_chain,
  input logic               glob_dis
);
  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_depth <= DEPTH_W'(MAX_DEPTH));

  a_r10_full_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (act_depth == DEPTH_W'(MAX_DEPTH)) |-> !entry_req);

  a_r6_preempt_nested: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (entry_req && act_depth != '0));

  a_r5_idle_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (act_depth == '0) |-> !preempt);

  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    glob_dis |-> !entry_req);

  a_r9_no_chain_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_dis && core_done) |=> !done_chain);

  a_r7_take_push: assert property (@(posedge clk) disable iff (!rst_n)
    (core_take && entry_req && !core_done) |=> act_depth == DEPTH_W'($past(act_depth) + 1'b1));

  a_r8_ret_pops: assert property (@(posedge clk) disable iff (!rst_n)
    done_ret |-> act_depth == DEPTH_W'($past(act_depth) - 1'b1));

  a_r8_chain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    done_chain |-> $stable(act_depth));

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ret && done_chain));

  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && act_depth == '0) |=> (act_depth == '0 && !done_ret && !done_chain));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_take  (core_take),
  .core_done  (core_done),
  .entry_req  (entry_req),
  .preempt    (preempt),
  .act_depth  (act_depth),
  .done_ret   (done_ret),
  .done_chain (done_chain),
  .glob_dis   (glob_dis)
);

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] req;
  logic         cfg_we;
  logic [5:0]   cfg_addr;
  logic [7:0]   cfg_wdata;
  logic         core_take, core_done;
  logic [7:0]   rdata, l_rdata;
  logic         entry_req, preempt, done_ret, done_chain;
  logic [4:0]   entry_vec, act_vec, act_depth;
  logic         l_entry_req, l_preempt, l_done_ret, l_done_chain;
  logic [4:0]   l_entry_vec, l_act_vec;
  logic [1:0]   l_act_depth;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .core_take(core_take), .core_done(core_done),
    .entry_req(entry_req), .preempt(preempt), .entry_vec(entry_vec), .act_vec(act_vec),
    .act_depth(act_depth), .done_ret(done_ret), .done_chain(done_chain)
  );

  // shallow-stack copy driven by the same inputs, used for the depth limit
  irq_nest_ctrl #(.MAX_DEPTH(2)) dut_lim (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(l_rdata), .core_take(core_take), .core_done(core_done),
    .entry_req(l_entry_req), .preempt(l_preempt), .entry_vec(l_entry_vec), .act_vec(l_act_vec),
    .act_depth(l_act_depth), .done_ret(l_done_ret), .done_chain(l_done_chain)
  );

  typedef struct packed {
    logic [4:0] la; logic [1:0] pa;
    logic [4:0] lb; logic [1:0] pb;
    logic       same;
    logic [4:0] win; logic [4:0] oth;
  } vec_t;

  // R4 arbitration pairs: staggered equal, older-but-higher line, same-cycle tie, urgency over age
  localparam vec_t VT [5] = '{
    '{5'd3,  2'd2, 5'd7,  2'd2, 1'b0, 5'd3,  5'd7},
    '{5'd9,  2'd2, 5'd4,  2'd2, 1'b0, 5'd9,  5'd4},
    '{5'd12, 2'd1, 5'd5,  2'd1, 1'b1, 5'd5,  5'd12},
    '{5'd20, 2'd3, 5'd30, 2'd0, 1'b0, 5'd30, 5'd20},
    '{5'd31, 2'd0, 5'd0,  2'd1, 1'b1, 5'd31, 5'd0}
  };

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_req(input int line);
    req[line] = 1'b1;
    step(1);
    req[line] = 1'b0;
  endtask

  task automatic take;
    core_take = 1'b1;
    step(1);
    core_take = 1'b0;
  endtask

  task automatic done;
    core_done = 1'b1;
    step(1);
    core_done = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; req = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    core_take = 1'b0; core_done = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state
    check("R5 reset entry_req", entry_req, 0);
    check("R6 reset preempt", preempt, 0);
    check("R7 reset depth", act_depth, 0);
    check("R8 reset done flags", {done_ret, done_chain}, 0);
    rd(6'd5, d);  check("R2 reset level", d, 0);
    rd(6'd32, d); check("R3 reset enables", d, 0);
    rd(6'd36, d); check("R9 reset disable", d, 0);

    // R2 field position
    wr(6'd5, 8'hFF); rd(6'd5, d); check("R2 level readback ff", d, 8'hC0);
    wr(6'd5, 8'h7F); rd(6'd5, d); check("R2 level readback 7f", d, 8'h40);

    // R11 stray take and done
    take;  check("R11 take without offer", act_depth, 0);
    done;  check("R11 done when idle depth", act_depth, 0);
    check("R11 done when idle pulses", {done_ret, done_chain}, 0);

    // R3 disabled line latches, joins when enabled
    wr(6'd6, 8'h00);
    pulse_req(6); step(3);
    check("R3 disabled line not offered", entry_req, 0);
    wr(6'd32, 8'h40); rd(6'd32, d); check("R3 enable readback", d, 8'h40);
    step(2);
    check("R3 latched line offered", entry_req, 1);
    check("R3 latched line vector", entry_vec, 6);
    take; check("R1 taken line pending clears", entry_req, 0);
    step(2); done; check("R8 return to thread", done_ret, 1);
    for (int b = 0; b < 4; b++) wr(6'(32 + b), 8'hFF);

    // table-driven arbitration
    for (int k = 0; k < 5; k++) begin
      wr(6'(VT[k].la), {VT[k].pa, 6'b0});
      wr(6'(VT[k].lb), {VT[k].pb, 6'b0});
      req[VT[k].la] = 1'b1;
      if (!VT[k].same) begin step(1); req[VT[k].la] = 1'b0; end
      req[VT[k].lb] = 1'b1;
      step(1);
      req[VT[k].la] = 1'b0; req[VT[k].lb] = 1'b0;
      step(3);
      check($sformatf("R5 vec%0d offer", k), entry_req, 1);
      check($sformatf("R4 vec%0d winner", k), entry_vec, VT[k].win);
      take;
      check($sformatf("R7 vec%0d depth", k), act_depth, 1);
      check($sformatf("R7 vec%0d active", k), act_vec, VT[k].win);
      step(2);
      check($sformatf("R6 vec%0d no preempt", k), preempt, 0);
      done;
      check($sformatf("R8 vec%0d chain", k), done_chain, 1);
      check($sformatf("R8 vec%0d chained vec", k), act_vec, VT[k].oth);
      check($sformatf("R8 vec%0d chain depth", k), act_depth, 1);
      step(2);
      done;
      check($sformatf("R8 vec%0d return", k), done_ret, 1);
      check($sformatf("R8 vec%0d final depth", k), act_depth, 0);
      step(1);
    end

    // R9 global disable
    wr(6'd36, 8'h01); wr(6'd8, 8'h00); wr(6'd9, 8'h00);
    pulse_req(8); step(3);
    check("R9 disabled no offer", entry_req, 0);
    wr(6'd36, 8'h00); step(2);
    check("R9 latched while disabled", entry_req, 1);
    check("R9 latched vector", entry_vec, 8);
    take; wr(6'd36, 8'h01);
    pulse_req(9); step(3);
    done;
    check("R9 no chain while disabled", done_chain, 0);
    check("R9 return while disabled", done_ret, 1);
    wr(6'd36, 8'h00); step(2);
    check("R9 pending after enable", entry_vec, 9);
    take; step(2); done;
    check("R8 drain after R9", act_depth, 0);

    // nesting: preempt, wait, chain, return
    wr(6'd1, 8'h80); wr(6'd2, 8'h40); wr(6'd3, 8'h40); wr(6'd4, 8'hC0);
    pulse_req(1); step(3); take; step(2);
    pulse_req(2); step(3);
    check("R6 more urgent preempts", preempt, 1);
    check("R6 preempt vector", entry_vec, 2);
    take;
    check("R7 nested depth", act_depth, 2);
    req[3] = 1'b1; req[4] = 1'b1; step(1); req[3] = 1'b0; req[4] = 1'b0; step(3);
    check("R6 equal level waits", entry_req, 0);
    check("R6 equal level no preempt", preempt, 0);
    done;
    check("R8 chain over interrupted", done_chain, 1);
    check("R8 chain vector", act_vec, 3);
    check("R8 chain depth", act_depth, 2);
    step(2); done;
    check("R8 return to interrupted", done_ret, 1);
    check("R8 return depth", act_depth, 1);
    check("R8 return vector", act_vec, 1);
    step(2);
    check("R6 less urgent waits", entry_req, 0);
    done;
    check("R8 chain at base level", done_chain, 1);
    check("R8 base chain vector", act_vec, 4);
    step(2); done;
    check("R8 nest drained", act_depth, 0);

    // R10 depth limit on the shallow copy
    wr(6'd10, 8'hC0); wr(6'd11, 8'h80); wr(6'd12, 8'h40);
    pulse_req(10); step(3); take; step(2);
    pulse_req(11); step(3); take; step(2);
    pulse_req(12); step(3);
    check("R10 deep stack preempts", preempt, 1);
    check("R10 full stack depth", l_act_depth, 2);
    check("R10 full stack no offer", l_entry_req, 0);
    check("R10 full stack no preempt", l_preempt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule